// File: doc/BRIEF.md
# Coprocessor Deferred Exception Responder

This block sits on the coprocessor side of a host/coprocessor handshake. The host starts a coprocessor instruction by writing a command word (general instruction) or a condition word (conditional instruction). It then reads the response register, and the value it reads is a primitive telling it what to do next. A general instruction that no longer needs the host gets a release primitive with the come-again bit clear. The coprocessor then goes on with that operation concurrently while the host continues with its own work.

An exception raised during that concurrent work is not reported at once. It is latched together with its vector number. It is reported only on the first response read after the host starts its next general or conditional instruction, and it is reported as a take-preinstruction-exception primitive. The host handles the exception and then restarts the instruction that received the primitive. Starting an instruction whose word the block does not recognise produces the same primitive, carrying a fixed vector for unrecognised words. The address of each recoverable concurrent instruction and the latched vector can be read through an operand register so that a handler can locate the faulting instruction.

Top module: `cp_defer_resp`

## Requirements
- R1: A synchronous reset clears any pending exception, ends any running operation and leaves no start pending. After reset a response read returns 16'h0000, and both operand selections read 0.
- R2: A command word is recognised when bits [6:0] are below NUM_OPS (96). A condition word is recognised when bits [5:0] are below NUM_PREDS (32). Bit 7 of a command word marks it as recoverable.
- R3: When a recognised command has been started, no operation is running and no exception is pending, the next response read returns the release primitive 16'h0000 (come-again bit 15 clear) and starts a concurrent operation. From then on, reads with no start pending return 16'h8000 until execDone or execExc ends the operation.
- R4: When an instruction is started while the concurrent operation is still running and no exception is pending, the response read returns the busy primitive 16'h8000 (come-again set). The start stays pending, so a read after the operation ends returns that instruction's normal primitive.
- R5: An exception raised through execExc while an operation runs ends the operation and is held. Response reads with no start pending never return a take-preinstruction primitive, and they leave the held exception in place.
- R6: The first response read after a start, while an exception is held, returns 16'h1C00 OR'd with the latched vector in bits [7:0], and clears the held exception. Reporting it takes precedence over word recognition.
- R7: Starting an unrecognised word with no exception held makes the next response read return 16'h1C00 | ILL_VEC (default 8'h0B).
- R8: A take-preinstruction primitive is given only on the first response read after a start, before the started instruction has done anything. Writing the same word again is a fresh start, and its read returns the normal primitive.
- R9: For a recognised started condition word, the response read returns 16'h0000 with bit 0 equal to condTrue.
- R10: On a release read of a command with bit 7 set, wrAddr from its start write is recorded. oprSel=0 reads the recorded address. oprSel=1 reads the latched exception vector, zero-extended.
- R11: execExc and execDone have no effect while no operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Host write strobe that starts an instruction |
| wrIsCond | input | 1 | 1 = condition register written, 0 = command register |
| wrData | input | 16 | Written command or condition word |
| wrAddr | input | ADDR_W | Address of the instruction being started |
| condTrue | input | 1 | Evaluated predicate returned for condition words |
| rdEn | input | 1 | Host response-register read strobe |
| rspData | output | 16 | Primitive the current read returns |
| execDone | input | 1 | Concurrent operation finished normally |
| execExc | input | 1 | Concurrent operation raised an exception |
| execVec | input | VEC_W | Vector number of that exception |
| oprSel | input | 1 | Operand register select: 0 address, 1 vector |
| oprData | output | ADDR_W | Operand register contents |

## Verification
The bench goes after exceptions that arrive between instructions and are followed by several idle reads. A design that reports the exception early would return 16'h1C00-class values on those reads, or would lose the exception before the next start. It starts instructions while the operation is still running and checks that a busy reply keeps the start pending, so a design that drops the start returns idle zero afterwards. It repeats the exact word that just drew the take-preinstruction primitive, which catches a design that fails to clear the held exception or fails to treat the rewrite as a new start. It also drives execExc while the block is idle and checks unrecognised words against the held-exception precedence, which exposes designs that latch stray exceptions or use the wrong vector.

// File: rtl/cp_defer_pkg.sv
package cp_defer_pkg;

  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_BUSY,
    SEL_PRE_EXC,
    SEL_PRE_ILL,
    SEL_RELEASE,
    SEL_COND
  } rspSel_e;

  typedef struct packed {
    logic    latchCmd;
    logic    latchVec;
    logic    recordAddr;
    rspSel_e rspSel;
  } ctlStrobe_t;

  localparam logic [15:0] PRIM_CA_BIT   = 16'h8000;
  localparam logic [15:0] PRIM_PRE_BASE = 16'h1C00;
  localparam logic [15:0] PRIM_NULL     = 16'h0000;

endpackage

// File: rtl/cp_defer_dp.sv
module cp_defer_dp
  import cp_defer_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int OP_W      = 7,
  parameter int NUM_OPS   = 96,
  parameter int PRED_W    = 6,
  parameter int NUM_PREDS = 32,
  parameter logic [VEC_W-1:0] ILL_VEC = 8'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        stb,
  input  logic              wrIsCond,
  input  logic [15:0]       wrData,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              condTrue,
  input  logic [VEC_W-1:0]  execVec,
  input  logic              oprSel,
  output logic              wordOk,
  output logic              wordIsCond,
  output logic [15:0]       rspData,
  output logic [ADDR_W-1:0] oprData
);

  localparam logic [OP_W-1:0]   OP_LIM   = OP_W'(NUM_OPS - 1);
  localparam logic [PRED_W-1:0] PRED_LIM = PRED_W'(NUM_PREDS - 1);
  localparam int RECOV_BIT = OP_W;

  logic [15:0]       curWord;
  logic              curIsCond;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] recAddr;
  logic [VEC_W-1:0]  excVec;
  logic              opOk;
  logic              predOk;

  // start-word latch
  always_ff @(posedge clk) begin
    if (rst) begin
      curWord   <= '0;
      curIsCond <= 1'b0;
      curAddr   <= '0;
    end else if (stb.latchCmd) begin
      curWord   <= wrData;
      curIsCond <= wrIsCond;
      curAddr   <= wrAddr;
    end
  end

  // handler-visible registers
  always_ff @(posedge clk) begin
    if (rst) begin
      recAddr <= '0;
      excVec  <= '0;
    end else begin
      if (stb.recordAddr && curWord[RECOV_BIT]) recAddr <= curAddr;
      if (stb.latchVec) excVec <= execVec;
    end
  end

  always_comb begin
    opOk       = curWord[OP_W-1:0] <= OP_LIM;
    predOk     = curWord[PRED_W-1:0] <= PRED_LIM;
    wordOk     = curIsCond ? predOk : opOk;
    wordIsCond = curIsCond;
  end

  always_comb begin
    unique case (stb.rspSel)
      SEL_BUSY:    rspData = PRIM_CA_BIT;
      SEL_PRE_EXC: rspData = PRIM_PRE_BASE | 16'(excVec);
      SEL_PRE_ILL: rspData = PRIM_PRE_BASE | 16'(ILL_VEC);
      SEL_RELEASE: rspData = PRIM_NULL;
      SEL_COND:    rspData = PRIM_NULL | {15'b0, condTrue};
      default:     rspData = PRIM_NULL;
    endcase
  end

  assign oprData = oprSel ? ADDR_W'(excVec) : recAddr;

  // R10: address moves only on a recoverable release
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(stb.recordAddr && curWord[RECOV_BIT]) |=> $stable(recAddr)); // R10
  // R6: the exception primitive carries the latched vector
  AST_PRE_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (stb.rspSel == SEL_PRE_EXC) |-> (rspData[7:0] == 8'(excVec) && rspData[15:8] == 8'h1C)); // R6

endmodule

// File: rtl/cp_defer_ctrl.sv
module cp_defer_ctrl
  import cp_defer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       execDone,
  input  logic       execExc,
  input  logic       wordOk,
  input  logic       wordIsCond,
  output ctlStrobe_t stb
);

  logic startPend;
  logic opBusy;
  logic excPend;
  rspSel_e sel;
  logic rdStart;

  always_comb begin
    if (startPend) begin
      if (excPend)         sel = SEL_PRE_EXC;
      else if (!wordOk)    sel = SEL_PRE_ILL;
      else if (opBusy)     sel = SEL_BUSY;
      else if (wordIsCond) sel = SEL_COND;
      else                 sel = SEL_RELEASE;
    end else begin
      sel = opBusy ? SEL_BUSY : SEL_IDLE;
    end
  end

  assign rdStart = rdEn && startPend;

  always_comb begin
    stb.latchCmd   = wrEn;
    stb.latchVec   = opBusy && execExc;
    stb.recordAddr = rdStart && (sel == SEL_RELEASE);
    stb.rspSel     = sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startPend <= 1'b0;
      opBusy    <= 1'b0;
      excPend   <= 1'b0;
    end else begin
      if (wrEn)                              startPend <= 1'b1;
      else if (rdStart && sel != SEL_BUSY)   startPend <= 1'b0;

      if (rdStart && sel == SEL_PRE_EXC)     excPend <= 1'b0;
      else if (opBusy && execExc)            excPend <= 1'b1;

      if (opBusy && (execExc || execDone))   opBusy <= 1'b0;
      else if (rdStart && sel == SEL_RELEASE) opBusy <= 1'b1;
    end
  end

  // R1: reset leaves nothing pending
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!excPend && !opBusy && !startPend)); // R1
  // R5: held exception survives everything but its report
  AST_EXC_HELD: assert property (@(posedge clk) disable iff (rst)
    (excPend && !rdStart) |=> excPend); // R5
  // R6: reporting clears the held exception
  AST_EXC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (rdStart && excPend) |=> !excPend); // R6
  // R8: no take-preinstruction primitive without a fresh start
  AST_PRE_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_PRE_EXC || sel == SEL_PRE_ILL) |-> startPend); // R8
  // R4: a busy reply keeps the start pending
  AST_BUSY_KEEPS_START: assert property (@(posedge clk) disable iff (rst)
    (rdStart && sel == SEL_BUSY && !wrEn) |=> startPend); // R4
  // R3: release launches the concurrent operation
  AST_RELEASE_RUNS: assert property (@(posedge clk) disable iff (rst)
    (rdStart && sel == SEL_RELEASE) |=> opBusy); // R3
  // R11: no exception latched while idle
  AST_IDLE_NO_EXC: assert property (@(posedge clk) disable iff (rst)
    (!opBusy && !excPend) |=> !excPend || $past(opBusy)); // R11

endmodule

// File: rtl/cp_defer_resp.sv
module cp_defer_resp
  import cp_defer_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int OP_W      = 7,
  parameter int NUM_OPS   = 96,
  parameter int PRED_W    = 6,
  parameter int NUM_PREDS = 32,
  parameter logic [VEC_W-1:0] ILL_VEC = 8'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrIsCond,
  input  logic [15:0]       wrData,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              condTrue,
  input  logic              rdEn,
  output logic [15:0]       rspData,
  input  logic              execDone,
  input  logic              execExc,
  input  logic [VEC_W-1:0]  execVec,
  input  logic              oprSel,
  output logic [ADDR_W-1:0] oprData
);

  ctlStrobe_t stb;
  logic wordOk;
  logic wordIsCond;

  cp_defer_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn),
    .execDone(execDone), .execExc(execExc),
    .wordOk(wordOk), .wordIsCond(wordIsCond), .stb(stb)
  );

  cp_defer_dp #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .OP_W(OP_W), .NUM_OPS(NUM_OPS),
    .PRED_W(PRED_W), .NUM_PREDS(NUM_PREDS), .ILL_VEC(ILL_VEC)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .wrIsCond(wrIsCond), .wrData(wrData),
    .wrAddr(wrAddr), .condTrue(condTrue), .execVec(execVec), .oprSel(oprSel),
    .wordOk(wordOk), .wordIsCond(wordIsCond), .rspData(rspData), .oprData(oprData)
  );

endmodule

// File: tb/sim_cp_defer_resp.sv
module sim_cp_defer_resp;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 0, rst = 1;
  logic wrEn = 0, wrIsCond = 0, condTrue = 0, rdEn = 0;
  logic execDone = 0, execExc = 0, oprSel = 0;
  logic [15:0] wrData = 0;
  logic [AW-1:0] wrAddr = 0;
  logic [7:0] execVec = 0;
  logic [15:0] rspData;
  logic [AW-1:0] oprData;

  int nChk = 0, nBad = 0;
  bit done = 0;

  // reference state
  bit mStart, mBusy, mExc, mIsCond;
  logic [15:0] mWord;
  logic [AW-1:0] mAddrIn, mRec;
  logic [7:0] mVec;

  cp_defer_resp u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit wordKnown(bit isCond, logic [15:0] w);
    return isCond ? (w[5:0] < 32) : (w[6:0] < 96);
  endfunction

  function automatic logic [15:0] expRsp(bit ct);
    if (mStart) begin
      if (mExc) return 16'h1C00 | {8'h00, mVec};
      if (!wordKnown(mIsCond, mWord)) return 16'h1C0B;
      if (mBusy) return 16'h8000;
      if (mIsCond) return {15'b0, ct};
      return 16'h0000;
    end
    return mBusy ? 16'h8000 : 16'h0000;
  endfunction

  task automatic chk(string tag, logic [AW-1:0] got, logic [AW-1:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic doWrite(bit isCond, logic [15:0] w, logic [AW-1:0] a);
    @(negedge clk);
    wrEn = 1; wrIsCond = isCond; wrData = w; wrAddr = a;
    @(posedge clk); #1 wrEn = 0;
    mStart = 1; mIsCond = isCond; mWord = w; mAddrIn = a;
  endtask

  task automatic doRead(string tag, bit ct);
    logic [15:0] e;
    @(negedge clk);
    rdEn = 1; condTrue = ct;
    #1 e = expRsp(ct);
    chk(tag, AW'(rspData), AW'(e));
    @(posedge clk); #1 rdEn = 0;
    if (mStart) begin
      if (mExc) begin mExc = 0; mStart = 0; end
      else if (!wordKnown(mIsCond, mWord)) mStart = 0;
      else if (!mBusy) begin
        mStart = 0;
        if (!mIsCond) begin mBusy = 1; if (mWord[7]) mRec = mAddrIn; end
      end
    end
  endtask

  task automatic doExc(logic [7:0] v);
    @(negedge clk);
    execExc = 1; execVec = v;
    @(posedge clk); #1 execExc = 0;
    if (mBusy) begin mBusy = 0; mExc = 1; mVec = v; end
  endtask

  task automatic doDone();
    @(negedge clk);
    execDone = 1;
    @(posedge clk); #1 execDone = 0;
    mBusy = 0;
  endtask

  task automatic chkOpr(string tag);
    @(negedge clk);
    oprSel = 0; #1 chk({tag, " addr"}, oprData, mRec);
    oprSel = 1; #1 chk({tag, " vec"}, oprData, AW'(mVec));
    oprSel = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1;
    @(posedge clk); @(posedge clk); #1 rst = 0;
    mStart = 0; mBusy = 0; mExc = 0; mIsCond = 0; mWord = 0;
    mAddrIn = 0; mRec = 0; mVec = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    doReset();
    doRead("R1 reset rsp", 0);
    chkOpr("R1 reset opr");

    // R3 release + busy idle reads, R10 address record
    doWrite(0, 16'h0085, 32'hA000_0010);
    doRead("R3 release", 0);
    doRead("R3 busy idle", 0);
    chkOpr("R10 record");
    // R4 start while busy
    doWrite(0, 16'h0003, 32'hA000_0020);
    doRead("R4 busy start", 0);
    doDone();
    doRead("R4 after done", 0);
    // R5 exception held across idle reads
    doExc(8'h37);
    doRead("R5 idle read 1", 0);
    doRead("R5 idle read 2", 0);
    chkOpr("R10 vec");
    // R6 report after start, R8 restart gives normal
    doWrite(0, 16'h0002, 32'hA000_0030);
    doRead("R6 take pre", 0);
    doWrite(0, 16'h0002, 32'hA000_0030);
    doRead("R8 restart normal", 0);
    doDone();
    // R7 unrecognised, R2 boundary
    doWrite(0, 16'h0060, 32'h0);
    doRead("R7 unknown cmd", 0);
    doWrite(0, 16'h005F, 32'h0);
    doRead("R2 last op", 0);
    doDone();
    doWrite(1, 16'h0020, 32'h0);
    doRead("R2 unknown pred", 0);
    // R9 condition
    doWrite(1, 16'h001F, 32'h0);
    doRead("R9 cond true", 1);
    doWrite(1, 16'h0001, 32'h0);
    doRead("R9 cond false", 0);
    // R11 stray events while idle
    doExc(8'h44);
    doDone();
    doWrite(0, 16'h0070, 32'h0);
    doRead("R11 idle exc ignored", 0);
    chkOpr("R11 vec kept");
    // R6 exception precedence over unrecognised word
    doWrite(0, 16'h0004, 32'h0);
    doRead("R3 release 2", 0);
    doExc(8'h52);
    doWrite(0, 16'h007F, 32'h0);
    doRead("R6 precedence", 0);
    // R1 reset drops held exception
    doWrite(0, 16'h0001, 32'h0);
    doRead("R3 release 3", 0);
    doExc(8'h66);
    doReset();
    doWrite(0, 16'h0001, 32'h0);
    doRead("R1 reset cleared exc", 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0, 1: doWrite(0, {8'h00, 8'($urandom)}, $urandom);
        2:    doWrite(1, {10'h0, 6'($urandom)}, $urandom);
        3, 4, 5: doRead("R5 random read", 1'($urandom));
        6:    doExc(8'($urandom));
        7:    doDone();
        8:    chkOpr("R10 random");
        default: @(negedge clk);
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule